// File: doc/BRIEF.md
# Timestamp and Timer-Tick Generator

The block runs a 56-bit time counter that advances once per cycle of the reference crystal clock (nominally 19.2 MHz). Three coarse timestamps are taken from it, each the counter shifted right by a programmable amount. The logging stamp can instead come from a millisecond counter.

The same reference clock also feeds a gated divider. Its ratio is the programmed value plus one, and its output is the common timer tick. Three pulse generators count common ticks, and each emits a one-cycle strobe at its own selectable granularity. Downstream timers use these strobes as their time base.

All settings arrive through a write-only register port.

Top module: `timebase_tick_gen`

## Requirements
- R1: After reset the time counter is 0. It increments by one on every clock edge and wraps silently at 2^56.
- R2: The three stamp outputs are the low 32 bits of the time counter shifted right by their own shift amount (0 to 31). After reset the shifts are 14 for the log stamp, 14 for the tag stamp and 24 for the translation stamp.
- R3: The log stamp depends on its source-select bit. When the bit is 1, which is the reset value, the log stamp follows R2. When the bit is 0, it shows a millisecond count equal to floor(edges since reset / REF_PER_MS).
- R4: Register writes use wr_addr_i and take effect on the clock edge that samples wr_en_i.
  - Address 0 holds the divide value in bits 15:0 and the divider enable in bit 31.
  - Address 1 holds the log shift in bits 4:0, the tag shift in bits 12:8, the translation shift in bits 20:16 and the log source select in bit 24.
  - Address 2 holds the granularity codes of generators 0, 1 and 2 in bits 2:0, 6:4 and 10:8.
  - A write to address 3 changes nothing.
- R5: The divider ratio is the divide value plus one. After reset the divide value is 191 (ratio 192) and the divider is enabled.
- R6: While the divider enable is 0, the divider and all generators hold at zero and no tick is emitted. Counting restarts from zero when the enable is set.
- R7: Granularity code c selects a period, counted in common ticks, of 1, 2, 5, 10, 20, 50, 100 or 200 for c = 0 to 7. After reset the codes are 3 for generator 0 and 6 for generators 1 and 2, which gives 100 us and 1 ms at a 100 kHz common tick.
- R8: The enable write is sampled at edge E. With ratio N and period P, tick_o[g] is a one-cycle strobe that is high after edges E+1+k·P·N for k ≥ 1 and low otherwise. Out of reset, E is taken as the edge one before the first edge.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Register write data |
| log_stamp_o | output | 32 | Logging timestamp |
| tag_stamp_o | output | 32 | Tag timestamp |
| xlat_stamp_o | output | 32 | Address-translation timestamp |
| tick_o | output | 3 | Per-generator tick strobes |

## Verification
The stamps are combinational from registered state, so a register write shows on them in the half-cycle after the edge that samples it. The bench keeps its own edge count and compares at the following falling edge.

Tick strobes carry two registers of latency: one in the divider and one in the generator. The bench numbers the edges after the enable write and expects generator g high exactly after edges 1+k·P·N. It compares every cycle of a window that covers several periods, so a strobe that comes one cycle early or late, or that lasts too long, is caught. The default tick after reset is checked at edges 1920 and 1921.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int DIV_W   = 16;
  localparam int SH_W    = 5;
  localparam int GRAN_W  = 3;
  localparam int NUM_GEN = 3;
  localparam int PG_W    = 8;

  localparam logic [1:0] ADDR_DIV   = 2'd0;
  localparam logic [1:0] ADDR_STAMP = 2'd1;
  localparam logic [1:0] ADDR_GRAN  = 2'd2;

  typedef struct packed {
    logic                             div_en;
    logic [DIV_W-1:0]                 div_val;
    logic                             log_sel;
    logic [SH_W-1:0]                  log_sh;
    logic [SH_W-1:0]                  tag_sh;
    logic [SH_W-1:0]                  xlat_sh;
    logic [NUM_GEN-1:0][GRAN_W-1:0]   gran;
  } cfg_t;

  function automatic logic [PG_W-1:0] gran_period(input logic [GRAN_W-1:0] code);
    case (code)
      3'd0:    return 8'd1;
      3'd1:    return 8'd2;
      3'd2:    return 8'd5;
      3'd3:    return 8'd10;
      3'd4:    return 8'd20;
      3'd5:    return 8'd50;
      3'd6:    return 8'd100;
      default: return 8'd200;
    endcase
  endfunction
endpackage

// File: rtl/tbg_regs.sv
module tbg_regs
  import tbg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  output cfg_t        cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.div_en  <= 1'b1;
      cfg_q.div_val <= DIV_W'(191);
      cfg_q.log_sel <= 1'b1;
      cfg_q.log_sh  <= SH_W'(14);
      cfg_q.tag_sh  <= SH_W'(14);
      cfg_q.xlat_sh <= SH_W'(24);
      cfg_q.gran[0] <= 3'd3;
      cfg_q.gran[1] <= 3'd6;
      cfg_q.gran[2] <= 3'd6;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_DIV: begin
          cfg_q.div_val <= wr_data_i[DIV_W-1:0];
          cfg_q.div_en  <= wr_data_i[31];
        end
        ADDR_STAMP: begin
          cfg_q.log_sh  <= wr_data_i[4:0];
          cfg_q.tag_sh  <= wr_data_i[12:8];
          cfg_q.xlat_sh <= wr_data_i[20:16];
          cfg_q.log_sel <= wr_data_i[24];
        end
        ADDR_GRAN: begin
          cfg_q.gran[0] <= wr_data_i[2:0];
          cfg_q.gran[1] <= wr_data_i[6:4];
          cfg_q.gran[2] <= wr_data_i[10:8];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  a_r4_div_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_DIV) |=>
      (cfg_q.div_val == $past(wr_data_i[DIV_W-1:0]) && cfg_q.div_en == $past(wr_data_i[31])));

  a_r4_unused_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> $stable(cfg_q));
endmodule

// File: rtl/tbg_divider.sv
module tbg_divider
  import tbg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             tmr_tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= div_val_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tmr_tick_o = tick_q;

  a_r6_div_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tmr_tick_o && cnt_q == '0));

  // a tick always lands on a counter restart
  a_r5_tick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_o |-> cnt_q == '0);
endmodule

// File: rtl/tbg_pulse_gen.sv
module tbg_pulse_gen
  import tbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tmr_tick_i,
  input  logic [GRAN_W-1:0] gran_i,
  output logic              tick_o
);
  logic [PG_W-1:0] cnt_q;
  logic [PG_W-1:0] last;
  logic            tick_q;

  assign last = gran_period(gran_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (tmr_tick_i) begin
      if (cnt_q >= last) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  a_r8_tick_after_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(tmr_tick_i));

  a_r6_gen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
endmodule

// File: rtl/timebase_tick_gen.sv
module timebase_tick_gen
  import tbg_pkg::*;
#(
  parameter int TB_W       = 56,
  parameter int STAMP_W    = 32,
  parameter int REF_PER_MS = 19200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  output logic [STAMP_W-1:0] log_stamp_o,
  output logic [STAMP_W-1:0] tag_stamp_o,
  output logic [STAMP_W-1:0] xlat_stamp_o,
  output logic [NUM_GEN-1:0] tick_o
);
  localparam int MS_W = $clog2(REF_PER_MS + 1);

  cfg_t               cfg;
  logic [TB_W-1:0]    tb_q;
  logic [MS_W-1:0]    sub_q;
  logic [STAMP_W-1:0] ms_q;
  logic               tmr_tick;
  logic [TB_W-1:0]    log_sh_tb, tag_sh_tb, xlat_sh_tb;

  tbg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_q <= '0;
    else         tb_q <= tb_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      ms_q  <= '0;
    end else if (sub_q == MS_W'(REF_PER_MS - 1)) begin
      sub_q <= '0;
      ms_q  <= ms_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign log_sh_tb  = tb_q >> cfg.log_sh;
  assign tag_sh_tb  = tb_q >> cfg.tag_sh;
  assign xlat_sh_tb = tb_q >> cfg.xlat_sh;

  assign log_stamp_o  = cfg.log_sel ? log_sh_tb[STAMP_W-1:0] : ms_q;
  assign tag_stamp_o  = tag_sh_tb[STAMP_W-1:0];
  assign xlat_stamp_o = xlat_sh_tb[STAMP_W-1:0];

  tbg_divider u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg.div_en),
    .div_val_i  (cfg.div_val),
    .tmr_tick_o (tmr_tick)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    tbg_pulse_gen u_pg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cfg.div_en),
      .tmr_tick_i (tmr_tick),
      .gran_i     (cfg.gran[g]),
      .tick_o     (tick_o[g])
    );
  end

  a_r1_tb_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tb_q == $past(tb_q) + 1'b1);

  a_r3_ms_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ms_q) |-> ms_q == $past(ms_q) + 1'b1);
endmodule

// File: tb/timebase_tick_gen_test.sv
`timescale 1ns/1ps
module timebase_tick_gen_test;
  localparam int REF_MS = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] log_st, tag_st, xlat_st;
  logic [2:0]  tick;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  longint unsigned cyc;

  always #2.5 clk = ~clk;

  timebase_tick_gen #(.REF_PER_MS(REF_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .log_stamp_o(log_st), .tag_stamp_o(tag_st),
    .xlat_stamp_o(xlat_st), .tick_o(tick)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // {div_val[15:0], g0[2:0], g1[2:0], g2[2:0]}
  localparam logic [24:0] VEC [4] = '{
    {16'd1, 3'd0, 3'd1, 3'd2},
    {16'd2, 3'd3, 3'd0, 3'd1},
    {16'd0, 3'd0, 3'd2, 3'd4},
    {16'd4, 3'd1, 3'd0, 3'd3}
  };

  function automatic int per(input logic [2:0] c);
    case (c)
      3'd0: return 1;   3'd1: return 2;  3'd2: return 5;   3'd3: return 10;
      3'd4: return 20;  3'd5: return 50; 3'd6: return 100; default: return 200;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [31:0] sh(input longint unsigned v, input int s);
    longint unsigned t;
    t = v >> s;
    return t[31:0];
  endfunction

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R2 reset state
    chk(log_st == 0 && tag_st == 0 && xlat_st == 0, "R1 reset stamps", log_st, 0);
    chk(tick == 0, "R8 reset ticks", tick, 0);
    // R5/R7/R8 default: gen0 period 10 x ratio 192
    while (cyc < 1920) @(negedge clk);
    chk(tick[0] == 1'b0, "R8 default gen0 before", tick[0], 0);
    @(negedge clk);
    chk(tick[0] == 1'b1 && cyc == 1921, "R5 R7 default gen0 first tick", tick[0], 1);
    chk(tag_st == sh(cyc, 14) && log_st == sh(cyc, 14) && xlat_st == sh(cyc, 24),
        "R2 default shifts", tag_st, sh(cyc, 14));

    // vector table: R5 R7 R8
    foreach (VEC[v]) begin
      automatic int dv = int'(VEC[v][24:9]);
      automatic int nn = dv + 1;
      automatic int pp [3];
      automatic int bad [3] = '{0, 0, 0};
      automatic int win;
      pp[0] = per(VEC[v][8:6]); pp[1] = per(VEC[v][5:3]); pp[2] = per(VEC[v][2:0]);
      win = 3 * nn * 20 + 5;
      wr(2'd0, {1'b0, 15'd0, VEC[v][24:9]});
      wr(2'd2, {21'd0, VEC[v][2:0], 1'b0, VEC[v][5:3], 1'b0, VEC[v][8:6]});
      wr(2'd0, {1'b1, 15'd0, VEC[v][24:9]});
      for (int n = 0; n <= win; n++) begin
        if (n > 0) @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 3; g++) begin
          automatic int pn = pp[g] * nn;
          automatic bit e = (n > 1) && ((n - 1) % pn == 0);
          if (tick[g] != e) bad[g]++;
        end
      end
      for (int g = 0; g < 3; g++)
        chk(bad[g] == 0, $sformatf("R8 vec%0d gen%0d mismatched cycles", v, g), bad[g], 0);
    end

    // R6 disabled: no ticks
    begin
      automatic int seen = 0;
      wr(2'd0, 32'h0000_0000);
      for (int n = 0; n < 300; n++) begin
        @(negedge clk);
        if (tick != 0) seen++;
      end
      chk(seen == 0, "R6 disabled ticks", seen, 0);
    end

    // R2/R4 new shifts, visible right after the write edge
    wr(2'd1, {7'd0, 1'b1, 3'd0, 5'd9, 3'd0, 5'd3, 3'd0, 5'd0});
    @(negedge clk);
    chk(log_st == sh(cyc, 0), "R2 log shift 0", log_st, sh(cyc, 0));
    chk(tag_st == sh(cyc, 3), "R2 tag shift 3", tag_st, sh(cyc, 3));
    chk(xlat_st == sh(cyc, 9), "R2 xlat shift 9", xlat_st, sh(cyc, 9));
    wr(2'd1, {7'd0, 1'b1, 3'd0, 5'd31, 3'd0, 5'd31, 3'd0, 5'd31});
    @(negedge clk);
    chk(tag_st == 0 && xlat_st == 0, "R2 shift 31", tag_st, 0);

    // R4 address 3 ignored: stamps keep following shifts set above
    wr(2'd1, {7'd0, 1'b1, 3'd0, 5'd2, 3'd0, 5'd1, 3'd0, 5'd4});
    wr(2'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(log_st == sh(cyc, 4) && tag_st == sh(cyc, 1) && xlat_st == sh(cyc, 2),
        "R4 addr3 ignored stamps", tag_st, sh(cyc, 1));
    chk(tick == 0, "R4 addr3 ignored divider", tick, 0);

    // R3 ms fallback
    wr(2'd1, {7'd0, 1'b0, 3'd0, 5'd2, 3'd0, 5'd1, 3'd0, 5'd4});
    @(negedge clk);
    chk(log_st == 32'(cyc / REF_MS), "R3 ms stamp", log_st, cyc / REF_MS);
    repeat (450) @(negedge clk);
    chk(log_st == 32'(cyc / REF_MS), "R3 ms stamp later", log_st, cyc / REF_MS);

    // R6 re-enable restarts from zero, ratio 3, gen0 code 0
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h8000_0002);
    begin
      automatic int first = -1;
      for (int n = 1; n <= 10; n++) begin
        @(posedge clk);
        @(negedge clk);
        if (tick[0] && first < 0) first = n;
      end
      chk(first == 4, "R6 restart first tick edge", first, 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule